// File: doc/BRIEF.md
# E1 Receive Loss-of-Signal Conditioner

This block sits between the sliced E1 receive rails and a framer. On each pulse of the recovered-clock bit strobe it samples one positive-rail and one negative-rail pulse indication. It tracks two things. The first is how long the line has been silent. The second is how many ones arrived in fixed 512-bit windows, which is two E1 frames of 256 bits each.

A run of 128 silent bit periods declares loss of signal. Once declared, the condition is released only when 64 ones have been counted inside one window. The window positions are fixed, back to back, starting at reset.

Towards the framer the block drives:
- two conditioned rail outputs, each optionally inverted, and forced to a fixed level while loss of signal is active;
- a combined data output that stays transparent to the line;
- a loss-of-signal flag whose polarity is selectable.

Top module: `e1_los_conditioner`

## Requirements
- R1: Loss of signal becomes active on the strobed bit that completes 128 consecutive bit periods with no pulse on either rail. After 127 such periods it is still inactive.
- R2: Any strobed bit with a pulse on either rail restarts the silent-period count from zero.
- R3: While loss of signal is active, it is released on the strobed bit that brings the ones count to 64. The ones count covers the current 512-bit window only. Windows are fixed and back to back, and the first strobed bit after reset is bit 0 of a window. The count restarts at every window boundary and stays at zero while loss of signal is inactive.
- R4: A bit period with pulses on both rails counts as a single one.
- R5: With `los_pol_n` = 1, `los_flag` is 0 while loss of signal is active and 1 otherwise. With `los_pol_n` = 0 the flag is inverted.
- R6: With loss of signal inactive, each rail output equals the rail level captured at the last strobe when `rail_inv_n` = 1, and its complement when `rail_inv_n` = 0.
- R7: While loss of signal is active, both rail outputs are 1 when `rail_inv_n` = 0 and 0 when `rail_inv_n` = 1.
- R8: `data_out` is the OR of the two rail levels captured at the last strobe. It is unaffected by `rail_inv_n` and by loss of signal.
- R9: Clock edges without `bit_stb` change neither the loss-of-signal state nor the captured rail levels.
- R10: Synchronous reset clears the captured rails and all counters, and makes loss of signal active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_stb | input | 1 | One-cycle strobe per received bit period |
| rail_p_in | input | 1 | Positive-rail pulse indication for this bit |
| rail_n_in | input | 1 | Negative-rail pulse indication for this bit |
| rail_inv_n | input | 1 | 0 = invert rail outputs, 1 = pass through |
| los_pol_n | input | 1 | 0 = invert loss-of-signal flag, 1 = native active-low flag |
| rail_p_out | output | 1 | Conditioned positive rail |
| rail_n_out | output | 1 | Conditioned negative rail |
| data_out | output | 1 | OR of the captured rails |
| los_flag | output | 1 | Loss-of-signal flag, polarity per `los_pol_n` |

## Verification
A silent-period count that is off by one moves the loss-of-signal flag by one strobe, either at the 127th or at the 129th silent bit. The bench therefore checks both sides of the threshold.

A ones counter that is not restarted at a window boundary releases the flag too early when ones straddle two windows. A counter that counts a two-rail pulse twice releases the flag at the 32nd bit instead of the 64th. Both mistakes show on `los_flag` in the same strobe as the wrong count.

A wrong forcing or inversion term appears on the rail outputs on the first strobe after the state changes.

// File: rtl/e1_los_pkg.sv
package e1_los_pkg;

  // A bit period is a one when either rail pulsed; two rails count once.
  function automatic logic line_one(input logic p, input logic n);
    return p | n;
  endfunction

  // Rail conditioning: a forced rail reads as 0 before the optional inversion.
  function automatic logic cond_rail(input logic raw, input logic forced,
                                     input logic inv_n);
    return (forced ? 1'b0 : raw) ^ ~inv_n;
  endfunction

  // The native flag is active low; pol_n low flips it.
  function automatic logic flag_level(input logic los, input logic pol_n);
    return (~los) ^ (~pol_n);
  endfunction

endpackage

// File: rtl/e1_zero_run.sv
module e1_zero_run #(
  parameter int LIMIT = 128
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         stb,
  input  logic                         one,
  output logic [$clog2(LIMIT+1)-1:0]   run_cnt,
  output logic                         hit
);
  localparam int ZW = $clog2(LIMIT + 1);
  localparam logic [ZW-1:0] LIM = ZW'(LIMIT);

  // Asserted on the strobed bit that completes the silent run.
  assign hit = stb && !one && (run_cnt == LIM - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
    end else if (stb) begin
      if (one)
        run_cnt <= '0;
      else if (run_cnt != LIM)
        run_cnt <= run_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/e1_ones_window.sv
module e1_ones_window #(
  parameter int WINDOW = 512,
  parameter int NEED   = 64
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         stb,
  input  logic                         one,
  input  logic                         active,
  output logic [$clog2(NEED+1)-1:0]    ones_cnt,
  output logic                         wrap,
  output logic                         reach
);
  localparam int WW = $clog2(WINDOW);
  localparam int OW = $clog2(NEED + 1);
  localparam logic [WW-1:0] LAST = WW'(WINDOW - 1);
  localparam logic [OW-1:0] TOP  = OW'(NEED);

  logic [WW-1:0] win_pos;

  assign wrap  = stb && (win_pos == LAST);
  // The bit that closes a window still counts towards that window.
  assign reach = stb && active && one && (ones_cnt == TOP - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      win_pos <= '0;
    end else if (stb) begin
      win_pos <= (win_pos == LAST) ? '0 : win_pos + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ones_cnt <= '0;
    end else if (stb) begin
      if (wrap || !active)
        ones_cnt <= '0;
      else if (one && ones_cnt != TOP)
        ones_cnt <= ones_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/e1_rail_cond.sv
module e1_rail_cond
  import e1_los_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  logic p_in,
  input  logic n_in,
  input  logic los,
  input  logic inv_n,
  output logic p_out,
  output logic n_out,
  output logic d_out
);
  logic p_q, n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_q <= 1'b0;
      n_q <= 1'b0;
    end else if (stb) begin
      p_q <= p_in;
      n_q <= n_in;
    end
  end

  assign p_out = cond_rail(p_q, los, inv_n);
  assign n_out = cond_rail(n_q, los, inv_n);
  assign d_out = line_one(p_q, n_q);
endmodule

// File: rtl/e1_los_conditioner.sv
module e1_los_conditioner
  import e1_los_pkg::*;
#(
  parameter int ZERO_LIMIT  = 128,
  parameter int ONES_NEED   = 64,
  parameter int WINDOW_BITS = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_stb,
  input  logic rail_p_in,
  input  logic rail_n_in,
  input  logic rail_inv_n,
  input  logic los_pol_n,
  output logic rail_p_out,
  output logic rail_n_out,
  output logic data_out,
  output logic los_flag
);
  localparam int ZW = $clog2(ZERO_LIMIT + 1);
  localparam int OW = $clog2(ONES_NEED + 1);

  // Named internal events, visible to the bound checker.
  logic          pulse_seen;
  logic          zero_set_ev;
  logic          ones_clr_ev;
  logic          win_wrap;
  logic [ZW-1:0] zero_cnt;
  logic [OW-1:0] ones_cnt;
  logic          los_q;

  assign pulse_seen = line_one(rail_p_in, rail_n_in);

  e1_zero_run #(.LIMIT(ZERO_LIMIT)) u_zero (
    .clk     (clk),
    .rst     (rst),
    .stb     (bit_stb),
    .one     (pulse_seen),
    .run_cnt (zero_cnt),
    .hit     (zero_set_ev)
  );

  e1_ones_window #(.WINDOW(WINDOW_BITS), .NEED(ONES_NEED)) u_ones (
    .clk      (clk),
    .rst      (rst),
    .stb      (bit_stb),
    .one      (pulse_seen),
    .active   (los_q),
    .ones_cnt (ones_cnt),
    .wrap     (win_wrap),
    .reach    (ones_clr_ev)
  );

  // Loss-of-signal state; reset starts the block in loss.
  always_ff @(posedge clk) begin
    if (rst)
      los_q <= 1'b1;
    else if (zero_set_ev)
      los_q <= 1'b1;
    else if (ones_clr_ev)
      los_q <= 1'b0;
  end

  e1_rail_cond u_rail (
    .clk   (clk),
    .rst   (rst),
    .stb   (bit_stb),
    .p_in  (rail_p_in),
    .n_in  (rail_n_in),
    .los   (los_q),
    .inv_n (rail_inv_n),
    .p_out (rail_p_out),
    .n_out (rail_n_out),
    .d_out (data_out)
  );

  assign los_flag = flag_level(los_q, los_pol_n);
endmodule

// File: rtl/e1_los_chk.sv
module e1_los_chk #(
  parameter int ZW = 8,
  parameter int OW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          bit_stb,
  input logic          pulse_seen,
  input logic          zero_set_ev,
  input logic          ones_clr_ev,
  input logic          win_wrap,
  input logic [ZW-1:0] zero_cnt,
  input logic [OW-1:0] ones_cnt,
  input logic          los_q,
  input logic          rail_inv_n,
  input logic          rail_p_out,
  input logic          rail_n_out,
  input logic          data_out
);
  // R1: loss of signal only rises after a completed silent run
  p_rise_from_run_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(los_q) |-> $past(zero_set_ev));

  // R2: a strobed pulse restarts the silent count
  p_pulse_restarts_r2: assert property (@(posedge clk) disable iff (rst)
    (bit_stb && pulse_seen) |=> (zero_cnt == '0));

  // R3: release only through the ones-window event
  p_fall_from_ones_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(los_q) |-> $past(ones_clr_ev));

  // R3: the ones count starts afresh after each window boundary
  p_window_restart_r3: assert property (@(posedge clk) disable iff (rst)
    win_wrap |=> (ones_cnt == '0));

  // R7: rails held at the inversion-dependent level during loss
  p_forced_rails_r7: assert property (@(posedge clk) disable iff (rst)
    los_q |-> (rail_p_out == !rail_inv_n) && (rail_n_out == !rail_inv_n));

  // R9: no change without a strobe
  p_no_strobe_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !bit_stb |=> $stable(los_q) && $stable(data_out));
endmodule

bind e1_los_conditioner e1_los_chk #(.ZW(ZW), .OW(OW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bit_stb     (bit_stb),
  .pulse_seen  (pulse_seen),
  .zero_set_ev (zero_set_ev),
  .ones_clr_ev (ones_clr_ev),
  .win_wrap    (win_wrap),
  .zero_cnt    (zero_cnt),
  .ones_cnt    (ones_cnt),
  .los_q       (los_q),
  .rail_inv_n  (rail_inv_n),
  .rail_p_out  (rail_p_out),
  .rail_n_out  (rail_n_out),
  .data_out    (data_out)
);

// File: tb/sim_e1_los_conditioner.sv
module sim_e1_los_conditioner;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_stb = 1'b0;
  logic rp = 1'b0, rn = 1'b0;
  logic inv_n = 1'b1, pol_n = 1'b1;
  logic po, no, dout, flag;
  int   checks = 0;
  int   fails  = 0;

  always #4 clk = ~clk;   // 125 MHz

  e1_los_conditioner u0 (
    .clk(clk), .rst(rst), .bit_stb(bit_stb),
    .rail_p_in(rp), .rail_n_in(rn),
    .rail_inv_n(inv_n), .los_pol_n(pol_n),
    .rail_p_out(po), .rail_n_out(no),
    .data_out(dout), .los_flag(flag)
  );

  // Vector fields: {p, n, inv_n, pol_n, exp_p, exp_n, exp_d, exp_flag}.
  // Every vector is applied with loss of signal inactive.
  localparam logic [7:0] VEC [8] = '{
    8'b1011_1011, 8'b0110_0110, 8'b1001_0111, 8'b0100_1010,
    8'b1111_1111, 8'b0001_1101, 8'b1100_0010, 8'b0011_0001
  };

  task automatic check(input string req, input logic [3:0] act,
                       input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // One strobed bit; outputs are settled when the task returns.
  task automatic send_bit(input logic p, input logic n);
    @(negedge clk);
    rp = p; rn = n; bit_stb = 1'b1;
    @(posedge clk);
    #1 bit_stb = 1'b0;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    // R10 / R5 / R7: reset state
    check("R10 flag after reset", {3'b0, flag}, 4'h0);
    check("R7 rails forced low", {2'b0, po, no}, 4'h0);
    pol_n = 1'b0; #1;
    check("R5 inverted flag", {3'b0, flag}, 4'h1);
    pol_n = 1'b1; inv_n = 1'b0; #1;
    check("R7 rails forced high", {2'b0, po, no}, 4'h3);
    inv_n = 1'b1;

    // R4 / R3: two-rail bits count once; release at the 64th
    send_bit(1'b1, 1'b1);
    check("R8 data during loss", {3'b0, dout}, 4'h1);
    for (int i = 1; i < 63; i++) send_bit(1'b1, 1'b1);
    check("R4 still in loss after 63", {3'b0, flag}, 4'h0);
    send_bit(1'b1, 1'b1);
    check("R3 released at 64", {3'b0, flag}, 4'h1);

    // R6 / R8 / R5: table walk with loss inactive
    for (int v = 0; v < 8; v++) begin
      inv_n = VEC[v][5]; pol_n = VEC[v][4];
      send_bit(VEC[v][7], VEC[v][6]);
      check("R6 R8 R5 vector", {po, no, dout, flag}, VEC[v][3:0]);
    end
    inv_n = 1'b1; pol_n = 1'b1;

    // R1 / R2: silent run threshold and restart
    send_bit(1'b1, 1'b0);
    for (int i = 0; i < 127; i++) send_bit(1'b0, 1'b0);
    check("R1 not set at 127", {3'b0, flag}, 4'h1);
    send_bit(1'b0, 1'b1);
    for (int i = 0; i < 127; i++) send_bit(1'b0, 1'b0);
    check("R2 run restarted", {3'b0, flag}, 4'h1);
    send_bit(1'b0, 1'b0);
    check("R1 set at 128", {3'b0, flag}, 4'h0);

    // R9: unstrobed activity is ignored
    @(negedge clk);
    rp = 1'b1; rn = 1'b0;
    repeat (20) @(negedge clk);
    #1;
    check("R9 flag held", {3'b0, flag}, 4'h0);
    check("R9 data held", {3'b0, dout}, 4'h0);

    // R3: ones split across a window boundary do not release
    do_reset();
    for (int i = 0; i < 480; i++) send_bit(1'b0, 1'b0);
    for (int i = 480; i < 544; i++) send_bit(1'b1, 1'b0);
    check("R3 window restart holds loss", {3'b0, flag}, 4'h0);
    for (int i = 544; i < 575; i++) send_bit(1'b1, 1'b0);
    check("R3 63 in window", {3'b0, flag}, 4'h0);
    send_bit(1'b1, 1'b0);
    check("R3 64 in window", {3'b0, flag}, 4'h1);
    check("R6 pass after release", {2'b0, po, no}, 4'h2);

    finish_run();
  end
endmodule